// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host write port and a parallel flash array model. It turns host writes into the multi-cycle command protocol of a command-set flash. A write that starts a sequence sets the current command. Later writes supply data, a word count or a confirm code. The sequencer issues single-cycle program and erase requests toward the storage model. It keeps a sticky status byte and tells the read path which source to return: the array, status, identifier or query data.

Each write strobe is taken in one clock. Its command byte is the low eight bits of the data bus. Status, read mode and request outputs all change on the same edge that takes the write. When the device is marked read-only, program and erase requests are held back and error flags are raised in their place.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (0), the status byte is 0x00 and no program or erase request is raised.
- R2: Code 0x10 or 0x40 followed by one more write raises prog_req_o for one cycle with that write's address and data. It sets status bit 7 and leaves the read mode at status (1).
- R3: Code 0x20 followed by 0xD0 raises erase_req_o for one cycle. The request address is the 0x20 write's address with its low SECT_AW bits cleared. Status bit 7 is set.
- R4: Code 0x20 followed by any code other than 0xD0 raises no erase and returns the read mode to array.
- R5: With ro_i high, a program raises no request and sets status bit 4. An erase raises no request and sets status bit 5. Bit 7 is set in both cases.
- R6: Status bits 7, 5 and 4 stay set until code 0x50 is written, which clears the byte to 0x00 and selects array mode. Code 0x70 selects status mode (1).
- R7: Code 0x90 selects identifier mode (2). Code 0x98 selects query mode (3). In query mode any code other than 0xFF is ignored, and 0xFF returns to array mode.
- R8: Code 0xE8 sets status bit 7. The next write's low DEV_W bits give a count N. The N+1 writes after it each raise prog_req_o with their address and data.
- R9: After the last buffered data write, 0xD0 selects status mode. Any other code returns to array mode.
- R10: After code 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and selects status mode. Any other second code returns to array mode.
- R11: rd_status_o holds the status byte, zero-extended, in every DEV_W-bit lane of the data width.
- R12: An unrecognised code in the first cycle selects array mode, and the write after it is decoded as a new first-cycle command.
- R13: With wr_en_i low, status and read mode hold their values and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data; low byte is the command code |
| ro_i | input | 1 | Device is read-only |
| rd_mode_o | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| status_o | output | 8 | Status byte |
| rd_status_o | output | DW | Status replicated per device lane |
| prog_req_o | output | 1 | Program request pulse |
| erase_req_o | output | 1 | Sector erase request pulse |
| req_addr_o | output | AW | Request address |
| req_data_o | output | DW | Program data |

## Verification
The hardest case to reach is the end of a buffered write. The count comes from only the low lane of a wider data word, and the confirm has to land exactly after the N+1th data write. The bench loads a count word with a non-zero upper byte and issues exactly N+1 data writes. It then sends 0xD0 and expects no program request and status mode. A sequencer that ignored the mask or counted off by one would either take the confirm as data or drop back to array mode. A second run uses a zero count and ends with a bad confirm code, which covers the error exit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFWR   = 8'hE8;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_LOCK_B  = 8'h01;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ARG     = 2'd1,
    CYC_DATA    = 2'd2,
    CYC_CONFIRM = 2'd3
  } cyc_e;

  typedef struct packed {
    logic set_rdy;
    logic set_eerr;
    logic set_perr;
    logic clr;
  } sts_ev_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  cyc_e        cyc_i,
  input  logic [7:0]  cmd_i,
  input  logic [7:0]  code_i,
  input  logic        cnt_zero_i,
  input  logic        ro_i,
  output cyc_e        cyc_o,
  output logic [7:0]  cmd_o,
  output logic        prog_o,
  output logic        erase_o,
  output sts_ev_t     ev_o,
  output logic        cnt_load_o,
  output logic        cnt_dec_o
);
  always_comb begin
    cyc_o      = CYC_IDLE;
    cmd_o      = OP_ARRAY;
    prog_o     = 1'b0;
    erase_o    = 1'b0;
    ev_o       = '0;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    case (cyc_i)
      CYC_IDLE: begin
        case (code_i)
          OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY: begin
            cyc_o = CYC_ARG;
            cmd_o = code_i;
          end
          OP_BUFWR: begin
            cyc_o = CYC_ARG;
            cmd_o = code_i;
            ev_o.set_rdy = 1'b1;
          end
          OP_CLR:            ev_o.clr = 1'b1;
          OP_STAT, OP_IDENT: cmd_o = code_i;
          default: ;
        endcase
      end
      CYC_ARG: begin
        case (cmd_i)
          OP_PROG_A, OP_PROG_B: begin
            prog_o        = !ro_i;
            ev_o.set_perr = ro_i;
            ev_o.set_rdy  = 1'b1;
            cmd_o         = cmd_i;
          end
          OP_ERASE: begin
            if (code_i == OP_CONFIRM) begin
              erase_o       = !ro_i;
              ev_o.set_eerr = ro_i;
              ev_o.set_rdy  = 1'b1;
              cmd_o         = cmd_i;
            end
          end
          OP_BUFWR: begin
            cnt_load_o = 1'b1;
            cyc_o      = CYC_DATA;
            cmd_o      = cmd_i;
          end
          OP_LOCK: begin
            if (code_i == OP_CONFIRM || code_i == OP_LOCK_B) begin
              ev_o.set_rdy = 1'b1;
              cmd_o        = cmd_i;
            end
          end
          OP_QUERY: begin
            if (code_i != OP_ARRAY) begin
              cyc_o = CYC_ARG;
              cmd_o = cmd_i;
            end
          end
          default: ;
        endcase
      end
      CYC_DATA: begin
        prog_o        = !ro_i;
        ev_o.set_perr = ro_i;
        cmd_o         = cmd_i;
        if (cnt_zero_i) begin
          cyc_o = CYC_CONFIRM;
        end else begin
          cyc_o     = CYC_DATA;
          cnt_dec_o = 1'b1;
        end
      end
      CYC_CONFIRM: begin
        if (code_i == OP_CONFIRM) begin
          ev_o.set_rdy = 1'b1;
          cmd_o        = cmd_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sts_ev_t    ev_i,
  output logic [7:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
    end else if (ev_i.clr) begin
      status_o <= '0;
    end else begin
      if (ev_i.set_rdy)  status_o[7] <= 1'b1;
      if (ev_i.set_eerr) status_o[5] <= 1'b1;
      if (ev_i.set_perr) status_o[4] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_wbuf_cnt.sv
module flash_wbuf_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_lane_rep.sv
module flash_lane_rep #(
  parameter int DW    = 16,
  parameter int DEV_W = 8
) (
  input  logic [7:0]    status_i,
  output logic [DW-1:0] lanes_o
);
  localparam int LANES = DW / DEV_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lanes_o[l*DEV_W +: DEV_W] = DEV_W'(status_i);
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int DEV_W   = 8,
  parameter int SECT_AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ro_i,
  output logic [1:0]    rd_mode_o,
  output logic [7:0]    status_o,
  output logic [DW-1:0] rd_status_o,
  output logic          prog_req_o,
  output logic          erase_req_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o
);
  localparam logic [AW-1:0] SECT_MASK = ~AW'((1 << SECT_AW) - 1);

  cyc_e       cyc_q, cyc_d;
  logic [7:0] cmd_q, cmd_d;
  logic       prog_d, erase_d, cnt_load, cnt_dec, cnt_zero;
  sts_ev_t    ev_d, ev_g;
  logic [AW-1:0] sect_addr_q;

  flash_cmd_decode u_dec (
    .cyc_i      (cyc_q),
    .cmd_i      (cmd_q),
    .code_i     (wr_data_i[7:0]),
    .cnt_zero_i (cnt_zero),
    .ro_i       (ro_i),
    .cyc_o      (cyc_d),
    .cmd_o      (cmd_d),
    .prog_o     (prog_d),
    .erase_o    (erase_d),
    .ev_o       (ev_d),
    .cnt_load_o (cnt_load),
    .cnt_dec_o  (cnt_dec)
  );

  assign ev_g = wr_en_i ? ev_d : '0;

  flash_status_reg u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_g),
    .status_o (status_o)
  );

  flash_wbuf_cnt #(.CW(DEV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_en_i && cnt_load),
    .dec_i  (wr_en_i && cnt_dec),
    .val_i  (wr_data_i[DEV_W-1:0]),
    .zero_o (cnt_zero)
  );

  flash_lane_rep #(.DW(DW), .DEV_W(DEV_W)) u_rep (
    .status_i (status_o),
    .lanes_o  (rd_status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= CYC_IDLE;
      cmd_q       <= OP_ARRAY;
      sect_addr_q <= '0;
      prog_req_o  <= 1'b0;
      erase_req_o <= 1'b0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else begin
      prog_req_o  <= wr_en_i && prog_d;
      erase_req_o <= wr_en_i && erase_d;
      if (wr_en_i) begin
        cyc_q <= cyc_d;
        cmd_q <= cmd_d;
        // erase targets the sector named by the setup write
        if (cyc_q == CYC_IDLE) sect_addr_q <= wr_addr_i & SECT_MASK;
        req_addr_o <= erase_d ? sect_addr_q : wr_addr_i;
        req_data_o <= wr_data_i;
      end
    end
  end

  always_comb begin
    case (cmd_q)
      OP_ARRAY: rd_mode_o = RD_ARRAY;
      OP_IDENT: rd_mode_o = RD_IDENT;
      OP_QUERY: rd_mode_o = RD_QUERY;
      default:  rd_mode_o = RD_STATUS;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SECT_AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          ro_i,
  input logic [1:0]    rd_mode_o,
  input logic [7:0]    status_o,
  input logic          prog_req_o,
  input logic          erase_req_o,
  input logic [AW-1:0] req_addr_o
);
  // R13
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(status_o) && $stable(rd_mode_o) && !prog_req_o && !erase_req_o);

  // R3
  erase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> req_addr_o[SECT_AW-1:0] == '0);

  // R5
  ro_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ro_i |=> !prog_req_o && !erase_req_o);

  // R2
  prog_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> status_o[7] && rd_mode_o == 2'd1);

  // R3
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, erase_req_o}));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW), .SECT_AW(SECT_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .ro_i        (ro_i),
  .rd_mode_o   (rd_mode_o),
  .status_o    (status_o),
  .prog_req_o  (prog_req_o),
  .erase_req_o (erase_req_o),
  .req_addr_o  (req_addr_o)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 16, DW = 16, DEV_W = 8, SECT_AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          ro_i = 1'b0;
  logic [1:0]    rd_mode_o;
  logic [7:0]    status_o;
  logic [DW-1:0] rd_status_o;
  logic          prog_req_o, erase_req_o;
  logic [AW-1:0] req_addr_o;
  logic [DW-1:0] req_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic          s_pr, s_er;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;

  always #5 clk_i = ~clk_i;

  flash_cmd_seq #(.AW(AW), .DW(DW), .DEV_W(DEV_W), .SECT_AW(SECT_AW)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    #1;
    s_pr = prog_req_o; s_er = erase_req_o; s_addr = req_addr_o; s_data = req_data_o;
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", rd_mode_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 reqs", {prog_req_o, erase_req_o}, 0);
  endtask

  task automatic t_prog();
    wr(16'h0004, 16'h0010);
    chk("R2 mode after setup", rd_mode_o, 1);
    wr(16'h0123, 16'hBEEF);
    chk("R2 req", s_pr, 1);
    chk("R2 addr", s_addr, 16'h0123);
    chk("R2 data", s_data, 16'hBEEF);
    chk("R2 status", status_o, 8'h80);
    chk("R11 lanes", rd_status_o, 16'h8080);
    wr(16'h0000, 16'h0040);
    wr(16'h0200, 16'h1234);
    chk("R2 alt code req", {s_pr, s_data}, {1'b1, 16'h1234});
    repeat (3) @(posedge clk_i);
    #1;
    chk("R13 idle no req", {prog_req_o, erase_req_o}, 0);
    chk("R13 idle status", status_o, 8'h80);
    chk("R13 idle mode", rd_mode_o, 1);
  endtask

  task automatic t_clr();
    wr(16'h0, 16'h0050);
    chk("R6 clear status", status_o, 0);
    chk("R6 clear mode", rd_mode_o, 0);
    wr(16'h0, 16'h0070);
    chk("R6 status mode", rd_mode_o, 1);
  endtask

  task automatic t_erase();
    wr(16'h3456, 16'h0020);
    wr(16'h0000, 16'h00D0);
    chk("R3 erase req", {s_er, s_pr}, 2'b10);
    chk("R3 erase addr", s_addr, 16'h3400);
    chk("R3 status", status_o, 8'h80);
    wr(16'h0, 16'h0050);
    wr(16'h5678, 16'h0020);
    wr(16'h5678, 16'h0033);
    chk("R4 no erase", s_er, 0);
    chk("R4 mode", rd_mode_o, 0);
    chk("R4 status", status_o, 0);
    wr(16'h5678, 16'h0020);
    wr(16'h5678, 16'h00FF);
    chk("R4 abort by FF", {s_er, 1'b0, rd_mode_o}, 0);
  endtask

  task automatic t_ro();
    ro_i = 1'b1;
    wr(16'h0010, 16'h0010);
    wr(16'h0010, 16'hAAAA);
    chk("R5 prog blocked", s_pr, 0);
    chk("R5 prog err", status_o, 8'h90);
    wr(16'h0100, 16'h0020);
    wr(16'h0100, 16'h00D0);
    chk("R5 erase blocked", s_er, 0);
    chk("R6 sticky bits", status_o, 8'hB0);
    chk("R11 lanes ro", rd_status_o, 16'hB0B0);
    ro_i = 1'b0;
    wr(16'h0, 16'h0050);
    chk("R6 clear after errors", status_o, 0);
  endtask

  task automatic t_id();
    wr(16'h0, 16'h0090);
    chk("R7 ident", rd_mode_o, 2);
    wr(16'h0, 16'h0098);
    chk("R7 query", rd_mode_o, 3);
    wr(16'h0, 16'h0012);
    chk("R7 query ignore", rd_mode_o, 3);
    wr(16'h0, 16'h0070);
    chk("R7 query ignore 70", rd_mode_o, 3);
    wr(16'h0, 16'h00FF);
    chk("R7 query exit", rd_mode_o, 0);
  endtask

  task automatic t_buf();
    wr(16'h0100, 16'h00E8);
    chk("R8 ready on start", status_o, 8'h80);
    wr(16'h0100, 16'h0102);  // count 2 after masking
    chk("R8 count write no req", s_pr, 0);
    for (int i = 0; i < 3; i++) begin
      wr(16'h0100 + 16'(i), 16'hC000 + 16'(i));
      chk("R8 data req", {s_pr, s_addr, s_data}, {1'b1, 16'h0100 + 16'(i), 16'hC000 + 16'(i)});
    end
    wr(16'h0, 16'h00D0);
    chk("R9 confirm no req", s_pr, 0);
    chk("R9 confirm mode", rd_mode_o, 1);
    wr(16'h0, 16'h0050);
    wr(16'h0200, 16'h00E8);
    wr(16'h0200, 16'h0000);
    wr(16'h0200, 16'h7777);
    chk("R8 single data", {s_pr, s_data}, {1'b1, 16'h7777});
    wr(16'h0, 16'h0055);
    chk("R9 bad confirm", rd_mode_o, 0);
    chk("R9 bad confirm no req", s_pr, 0);
    wr(16'h0, 16'h0050);
  endtask

  task automatic t_lock();
    wr(16'h0, 16'h0060);
    wr(16'h0, 16'h00D0);
    chk("R10 D0 mode", rd_mode_o, 1);
    chk("R10 D0 ready", status_o, 8'h80);
    wr(16'h0, 16'h0050);
    wr(16'h0, 16'h0060);
    wr(16'h0, 16'h0001);
    chk("R10 01 mode", {status_o, 6'd0, rd_mode_o}, {8'h80, 8'h01});
    wr(16'h0, 16'h0060);
    wr(16'h0, 16'h00FF);
    chk("R10 FF mode", rd_mode_o, 0);
    wr(16'h0, 16'h0060);
    wr(16'h0, 16'h0033);
    chk("R10 bad mode", rd_mode_o, 0);
    wr(16'h0, 16'h0050);
  endtask

  task automatic t_unknown();
    wr(16'h0, 16'h0070);
    wr(16'h0, 16'h00AB);
    chk("R12 unknown to array", rd_mode_o, 0);
    wr(16'h0, 16'h0033);
    wr(16'h0, 16'h0090);
    chk("R12 next is command", rd_mode_o, 2);
    wr(16'h0, 16'h00FF);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_prog();
    t_clr();
    t_erase();
    t_ro();
    t_id();
    t_buf();
    t_lock();
    t_unknown();
    done = 1;
    finish_run();
  end
endmodule